// File: doc/BRIEF.md
# UTOPIA Level 2 Transmit Master

This block is the ATM-layer sending side of a UTOPIA Level 2 link with an 8-bit data path. It takes whole 53-byte cells from an internal byte stream (valid/ready handshake plus a start-of-cell flag) and delivers each one to a PHY device. All outputs are registered on the rising edge of the transmit clock, and all inputs are sampled on that edge.

In multi-PHY mode the block steps through the configured PHY addresses one per cycle. It keeps a one-bit cell-available record for each port, taken from the response that arrives one clock after the address. When a cell is waiting, it picks a ready port in round-robin order. It selects that port by driving the port's address with the active-low enable high for one cycle. It then streams the cell with the enable low. Polling continues while a cell is moving, so the records are up to date when the cell ends. In single-PHY mode the address bus rests at the null value and the cell-available input gates the start of each cell directly.

Top module: `utopia2_tx_master`

## Requirements
- R1: While reset is asserted and right after it, the enable is high, start-of-cell is low, the address is 31 (all ones, the null address) and `src_ready` is low. Every port record is cleared, so no port is selected until a poll response has set its record.
- R2: In multi-PHY mode, while no cell is moving, the address steps through 0 to `cfg_ports`-1 one per cycle in ascending order and wraps to 0. The cell-available level sampled at the following rising edge becomes that port's record (1 = ready).
- R3: A response that follows the null address, a select address or a reselect address is discarded. A served port is chosen again only after a later poll reports it ready.
- R4: Selection happens when the block is idle, the source shows valid with start-of-cell, and some port in range has its record set. The chosen port's address is driven with the enable high for one cycle, and that port's record is cleared. The enable goes low with the first byte on the next handshake.
- R5: The chosen port is the first ready port after the previously served one, in ascending order with wrap-around. After reset the search begins at port 0.
- R6: A cell is exactly 53 bytes, one byte per accepted handshake, each driven with the enable low. Start-of-cell is high only with the first byte. `src_ready` is high from the select cycle until the 53rd byte is accepted.
- R7: When the source stalls during a transfer, the enable goes high, start-of-cell stays low, the selected port's address is driven again, and polling pauses.
- R8: During a transfer, polling goes on with every cycle that carries a byte. The slot of the port being served is replaced by the null address.
- R9: In single-PHY mode the address stays at 31. A cell starts when the source shows valid with start-of-cell while the cell-available input is high. The enable is high for one cycle and then low with each byte.
- R10: Ports numbered `cfg_ports` and above are never polled or selected. `cfg_ports` (1 to 31) and `cfg_multi` change only while no cell is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY side |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_multi | input | 1 | 1 = multi-PHY polling mode, 0 = single-PHY mode |
| cfg_ports | input | 5 | Number of active PHY ports, 1 to 31 |
| src_valid | input | 1 | Source byte valid |
| src_sof | input | 1 | Source byte is the first of a cell |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block accepts a source byte this cycle |
| phy_clav | input | 1 | Cell-available response from the PHY side |
| phy_addr | output | 5 | PHY address for polling and selection, 31 = null |
| phy_enb_n | output | 1 | Active-low transmit enable |
| phy_soc | output | 1 | Start-of-cell marker, high with the first byte |
| phy_data | output | 8 | Transmit data byte |

## Verification
The embedded properties assume three things. The source only presents start-of-cell on the first byte of a 53-byte cell. The configuration inputs change only while no transfer is in progress. The cell-available input is valid at each rising edge. The stimulus follows all three: it builds cells byte by byte from a counter, and it changes `cfg_ports` and `cfg_multi` only after its own model reports the link idle with the source queue empty. It drives `phy_clav` half a cycle after every address change from a per-port ready table, and it deliberately returns a high level on the null address and on select addresses, so that the discard rules are exercised.

// File: rtl/utopia2_tx_master.sv
module utopia2_tx_master #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_multi,
  input  logic [ADDR_W-1:0] cfg_ports,
  input  logic              src_valid,
  input  logic              src_sof,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              phy_clav,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              phy_enb_n,
  output logic              phy_soc,
  output logic [DATA_W-1:0] phy_data
);
  localparam int NSLOT = 1 << ADDR_W;
  localparam int CNT_W = $clog2(CELL_BYTES + 1);
  localparam logic [ADDR_W-1:0] NULL_ADDR = {ADDR_W{1'b1}};

  logic              xfer_q, sel_q, enb_q, soc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] active_q, last_q, poll_q, addr_q;
  logic [NSLOT-1:0]  rec_q, live, above, elig, elig_hi;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] pick, cur_poll, nxt_poll;
  logic              start_m, start_s, last_byte;

  function automatic logic [ADDR_W-1:0] lowest(input logic [NSLOT-1:0] v);
    lowest = '0;
    for (int i = NSLOT - 1; i >= 0; i--) if (v[i]) lowest = ADDR_W'(i);
  endfunction

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      live[i]  = ADDR_W'(i) < cfg_ports;
      above[i] = ADDR_W'(i) > last_q;
    end
  end

  assign elig      = rec_q & live;
  assign elig_hi   = elig & above;
  assign pick      = (|elig_hi) ? lowest(elig_hi) : lowest(elig);
  assign cur_poll  = (poll_q < cfg_ports) ? poll_q : '0;
  assign nxt_poll  = (cur_poll + ADDR_W'(1) >= cfg_ports) ? '0 : cur_poll + ADDR_W'(1);
  assign start_m   = cfg_multi && src_valid && src_sof && (|elig);
  assign start_s   = !cfg_multi && src_valid && src_sof && phy_clav;
  assign last_byte = cnt_q == CNT_W'(CELL_BYTES - 1);

  assign src_ready = xfer_q;
  assign phy_addr  = addr_q;
  assign phy_enb_n = enb_q;
  assign phy_soc   = soc_q;
  assign phy_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else begin
      if (cfg_multi && !sel_q && addr_q != NULL_ADDR) rec_q[addr_q] <= phy_clav;
      if (!xfer_q && start_m) rec_q[pick] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q   <= 1'b0;
      cnt_q    <= '0;
      active_q <= '0;
      last_q   <= NULL_ADDR;
      poll_q   <= '0;
      addr_q   <= NULL_ADDR;
      sel_q    <= 1'b0;
      enb_q    <= 1'b1;
      soc_q    <= 1'b0;
      data_q   <= '0;
    end else if (!xfer_q) begin
      enb_q <= 1'b1;
      soc_q <= 1'b0;
      sel_q <= 1'b0;
      if (start_m) begin
        xfer_q   <= 1'b1;
        cnt_q    <= '0;
        active_q <= pick;
        last_q   <= pick;
        addr_q   <= pick;
        sel_q    <= 1'b1;
      end else if (start_s) begin
        xfer_q <= 1'b1;
        cnt_q  <= '0;
        addr_q <= NULL_ADDR;
      end else if (cfg_multi) begin
        addr_q <= cur_poll;
        poll_q <= nxt_poll;
      end else begin
        addr_q <= NULL_ADDR;
      end
    end else if (src_valid) begin
      data_q <= src_data;
      enb_q  <= 1'b0;
      soc_q  <= cnt_q == '0;
      cnt_q  <= cnt_q + CNT_W'(1);
      sel_q  <= 1'b0;
      if (last_byte) xfer_q <= 1'b0;
      if (cfg_multi) begin
        addr_q <= (cur_poll == active_q) ? NULL_ADDR : cur_poll;
        poll_q <= nxt_poll;
      end else begin
        addr_q <= NULL_ADDR;
      end
    end else begin
      enb_q  <= 1'b1;
      soc_q  <= 1'b0;
      addr_q <= cfg_multi ? active_q : NULL_ADDR;
      sel_q  <= cfg_multi;
    end
  end

  logic [CNT_W-1:0] chk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_q <= '0;
    else if (!phy_enb_n) chk_q <= phy_soc ? CNT_W'(1) : chk_q + CNT_W'(1);
  end

  p_soc_needs_enb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_soc |-> !phy_enb_n);
  p_cell_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_soc |-> (chk_q == '0 || chk_q == CNT_W'(CELL_BYTES)));
  p_cell_body_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_enb_n && !phy_soc) |-> (chk_q >= CNT_W'(1) && chk_q <= CNT_W'(CELL_BYTES - 1)));
  p_fall_after_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_multi && $fell(phy_enb_n)) |-> $past(phy_addr) == active_q);
  p_null_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_multi |=> phy_addr == NULL_ADDR);
  p_addr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_multi |=> (phy_addr == NULL_ADDR || phy_addr < $past(cfg_ports)));
endmodule

// File: tb/utopia2_tx_master_bench.sv
`timescale 1ns/1ps
module utopia2_tx_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_multi = 1'b1;
  logic [4:0] cfg_ports = 5'd4;
  logic       src_valid = 1'b0, src_sof = 1'b0, phy_clav = 1'b0;
  logic [7:0] src_data = 8'd0;
  logic       src_ready, phy_enb_n, phy_soc;
  logic [4:0] phy_addr;
  logic [7:0] phy_data;

  always #4 clk = ~clk;

  utopia2_tx_master u_utopia2_tx_master (
    .clk(clk), .rst_n(rst_n), .cfg_multi(cfg_multi), .cfg_ports(cfg_ports),
    .src_valid(src_valid), .src_sof(src_sof), .src_data(src_data), .src_ready(src_ready),
    .phy_clav(phy_clav), .phy_addr(phy_addr), .phy_enb_n(phy_enb_n),
    .phy_soc(phy_soc), .phy_data(phy_data));

  int checks = 0, fails = 0;
  string tag = "R1";

  // behavioural reference
  int m_xfer, m_cnt, m_active, m_last, m_poll, m_addr, m_sel, m_enb, m_soc, m_data;
  bit m_rec[32];
  bit hs_flag;
  int found, pk, p, p_eff, p_next;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_xfer = 0; m_cnt = 0; m_active = 0; m_last = 31; m_poll = 0;
      m_addr = 31; m_sel = 0; m_enb = 1; m_soc = 0; m_data = 0;
      foreach (m_rec[i]) m_rec[i] = 0;
      hs_flag = 0;
    end else begin
      hs_flag = (m_xfer != 0) && src_valid;
      found = 0; pk = 0;
      for (int k = 1; k <= 32; k++) begin
        p = (m_last + k) % 32;
        if (found == 0 && p < cfg_ports && m_rec[p]) begin found = 1; pk = p; end
      end
      p_eff  = (m_poll < cfg_ports) ? m_poll : 0;
      p_next = (p_eff + 1) % cfg_ports;
      if (cfg_multi && m_sel == 0 && m_addr != 31) m_rec[m_addr] = phy_clav;
      if (m_xfer == 0) begin
        m_enb = 1; m_soc = 0; m_sel = 0;
        if (cfg_multi && src_valid && src_sof && found != 0) begin
          m_xfer = 1; m_cnt = 0; m_active = pk; m_last = pk; m_addr = pk; m_sel = 1;
          m_rec[pk] = 0;
        end else if (!cfg_multi && src_valid && src_sof && phy_clav) begin
          m_xfer = 1; m_cnt = 0; m_addr = 31;
        end else if (cfg_multi) begin
          m_addr = p_eff; m_poll = p_next;
        end else m_addr = 31;
      end else if (src_valid) begin
        m_data = src_data; m_enb = 0; m_soc = (m_cnt == 0); m_sel = 0;
        m_cnt++;
        if (m_cnt == 53) m_xfer = 0;
        if (cfg_multi) begin
          m_addr = (p_eff == m_active) ? 31 : p_eff; m_poll = p_next;
        end else m_addr = 31;
      end else begin
        m_enb = 1; m_soc = 0;
        m_addr = cfg_multi ? m_active : 31; m_sel = cfg_multi;
      end
    end
  end

  // stimulus state
  int cells_left = 0, idx = 0, cell_id = 0, stall = 0, cyc = 0, flip_every = 0;
  bit phy_ok[32];
  bit sphy_ok = 1;
  int served[$];
  logic prev_enb = 1'b1;
  logic [4:0] prev_addr = 5'd31;

  task automatic check(input string req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d at cycle %0d", req, what, got, exp, cyc);
    end
  endtask

  task automatic compare();
    check(tag, phy_addr, m_addr, "phy_addr");
    check("R4", phy_enb_n, m_enb, "phy_enb_n");
    check("R6", phy_soc, m_soc, "phy_soc");
    check("R6", src_ready, m_xfer, "src_ready");
    if (m_enb == 0) check("R6", phy_data, m_data, "phy_data");
    if (cfg_multi && prev_enb && !phy_enb_n && phy_soc) served.push_back(prev_addr);
    prev_enb = phy_enb_n; prev_addr = phy_addr;
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (rst_n) compare();
    if (hs_flag) begin
      idx++;
      if (idx == 53) begin idx = 0; cells_left--; cell_id++; end
    end
    if (flip_every > 0 && cyc % flip_every == 0) begin
      phy_ok[$urandom_range(30)] ^= 1'b1;
      sphy_ok = ~sphy_ok;
    end
    src_valid = cells_left > 0 && ($urandom_range(99) >= stall);
    src_sof   = idx == 0;
    src_data  = 8'((cell_id * 13 + idx * 5) & 255);
    phy_clav  = cfg_multi ? ((phy_addr == 5'd31) ? 1'b1 : phy_ok[phy_addr]) : sphy_ok;
  endtask

  task automatic run_phase(input string t, input bit multi, input int n, input int st,
                           input int ncells, input int flip);
    tag = t; cfg_multi = multi; cfg_ports = 5'(n); stall = st; flip_every = flip;
    cells_left = ncells;
    while (cells_left > 0 || m_xfer != 0) cycle();
    repeat (8) cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", phy_addr, 31, "reset phy_addr");
    check("R1", phy_enb_n, 1, "reset phy_enb_n");
    check("R1", phy_soc, 0, "reset phy_soc");
    check("R1", src_ready, 0, "reset src_ready");
    foreach (phy_ok[i]) phy_ok[i] = 1'b1;
    rst_n = 1'b1;

    run_phase("R5", 1, 4, 0, 6, 0);
    check("R5", served.size(), 6, "served count");
    foreach (served[i]) check("R5", served[i], i % 4, "served port");

    run_phase("R7", 1, 4, 35, 4, 0);

    served.delete();
    for (int i = 0; i < 32; i++) phy_ok[i] = 1'b0;
    phy_ok[0] = 1'b1;
    run_phase("R3", 1, 1, 0, 3, 0);
    foreach (served[i]) check("R3", served[i], 0, "served port");

    for (int i = 0; i < 32; i++) phy_ok[i] = 1'b1;
    run_phase("R10", 1, 3, 10, 3, 0);

    run_phase("R2", 1, 31, 15, 3, 17);

    for (int i = 0; i < 32; i++) phy_ok[i] = (i % 3) != 2;
    run_phase("R8", 1, 6, 5, 4, 0);

    sphy_ok = 1'b0;
    run_phase("R9", 0, 6, 20, 4, 41);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule